// File: doc/BRIEF.md
# UDP/IPv4 Frame Header Streamer

This block produces the byte stream of one Ethernet frame carrying a UDP datagram over IPv4. The station and peer hardware addresses, the IPv4 source and destination, the two UDP ports and the payload size are held as static configuration inputs. Only the payload contents change from one frame to the next. A pulse on `start` launches a frame. The block first emits the 42 header bytes, then passes payload bytes through from a valid/ready payload source. When the payload is short, it appends zero bytes. It marks the final byte with `tx_last`.

The IPv4 header checksum and both length fields are derived inside the block from the configured fields and the payload size. The header checksum and the payload size are captured when a start is accepted. The output drives a downstream Manchester line transmitter through a valid/ready handshake. That transmitter appends the frame check sequence and the preamble.

Top module: `udp_hdr_streamer`

## Requirements
- R1: After reset `busy`, `tx_valid`, `tx_last` and `pl_ready` are all 0.
- R2: Header byte order is: peer address (6), station address (6), type 0x08 0x00, 0x45, service byte 0x00, total length (2), identifier 0x0000, flags/offset 0x0000, time to live `TTL` (default 64), protocol 17, header checksum (2), source IPv4 (4), destination IPv4 (4), source port (2), destination port (2), UDP length (2), UDP checksum (2). Every multi-byte field is sent most significant byte first.
- R3: IP total length (bytes 16-17) equals 28 plus the payload size. UDP length (bytes 38-39) equals 8 plus the payload size.
- R4: Bytes 24-25 carry the header checksum. It is the ones-complement of the ones-complement sum of the ten 16-bit header words, with the checksum word counted as zero.
- R5: Bytes 40-41, the UDP checksum, are always 0x00 0x00.
- R6: Payload bytes are forwarded in arrival order right after byte 41. `pl_ready` is high only while a payload byte is due and `tx_ready` is high.
- R7: When the payload is shorter than 18 bytes, 0x00 bytes follow it until the frame is 60 bytes long. Otherwise the frame is 42 plus the payload size.
- R8: `tx_last` is high only together with the final frame byte. `busy` falls after that byte is accepted.
- R9: A start arriving while `busy` is high is ignored: the frame in progress is unchanged and no further frame follows.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one frame when idle |
| busy | output | 1 | A frame is in progress |
| cfg_dst_mac | input | 48 | Peer hardware address |
| cfg_src_mac | input | 48 | Station hardware address |
| cfg_src_ip | input | 32 | IPv4 source address |
| cfg_dst_ip | input | 32 | IPv4 destination address |
| cfg_src_port | input | 16 | UDP source port |
| cfg_dst_port | input | 16 | UDP destination port |
| cfg_plen | input | PLEN_W | Payload size in bytes |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | Payload byte available |
| pl_ready | output | 1 | Payload byte taken |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte available |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The bench builds the block with its default `PLEN_W` of 11 and `TTL` of 64. It runs frames with payload sizes 0, 4, 18 and 30. These sizes cover the padded case, the exact 60-byte boundary and the unpadded case. Two different address and port sets are used, so the checksum carry folding runs on distinct sums. The frames are run under both steady and gapped `tx_ready`/`pl_valid` patterns, which covers stalls inside the header, the payload and the padding.

// File: rtl/udp_hdr_pkg.sv
package udp_hdr_pkg;
  localparam int HDR_BYTES   = 42;
  localparam int MIN_FRAME   = 60;
  localparam int IPH_BYTES   = 20;
  localparam int UDPH_BYTES  = 8;
  localparam logic [15:0] ETH_TYPE_V4 = 16'h0800;
  localparam logic [7:0]  VER_IHL     = 8'h45;
  localparam logic [7:0]  PROTO_UDP   = 8'd17;
endpackage

// File: rtl/udp_ipv4_csum.sv
module udp_ipv4_csum
  import udp_hdr_pkg::*;
#(
  parameter logic [7:0] TTL = 8'd64
) (
  input  logic [15:0] tot_len,
  input  logic [31:0] src_ip,
  input  logic [31:0] dst_ip,
  output logic [15:0] csum
);
  logic [19:0] sum;
  logic [16:0] fold1;
  logic [16:0] fold2;

  always_comb begin
    sum = {4'd0, VER_IHL, 8'h00} + {4'd0, tot_len}
        + {4'd0, TTL, PROTO_UDP}
        + {4'd0, src_ip[31:16]} + {4'd0, src_ip[15:0]}
        + {4'd0, dst_ip[31:16]} + {4'd0, dst_ip[15:0]};
    fold1 = {1'b0, sum[15:0]} + {13'd0, sum[19:16]};
    fold2 = {1'b0, fold1[15:0]} + {16'd0, fold1[16]};
    csum  = ~fold2[15:0];
  end
endmodule

// File: rtl/udp_hdr_bytes.sv
module udp_hdr_bytes
  import udp_hdr_pkg::*;
#(
  parameter logic [7:0] TTL = 8'd64
) (
  input  logic [5:0]  sel,
  input  logic [47:0] dst_mac,
  input  logic [47:0] src_mac,
  input  logic [31:0] src_ip,
  input  logic [31:0] dst_ip,
  input  logic [15:0] src_port,
  input  logic [15:0] dst_port,
  input  logic [15:0] tot_len,
  input  logic [15:0] udp_len,
  input  logic [15:0] csum,
  output logic [7:0]  hdr_byte
);
  localparam int HDR_BITS = HDR_BYTES * 8;
  logic [HDR_BITS-1:0] hdr;

  always_comb begin
    hdr = {dst_mac, src_mac, ETH_TYPE_V4, VER_IHL, 8'h00, tot_len,
           16'h0000, 16'h0000, TTL, PROTO_UDP, csum, src_ip, dst_ip,
           src_port, dst_port, udp_len, 16'h0000};
    if (int'(sel) < HDR_BYTES)
      hdr_byte = hdr[8*(HDR_BYTES-1-int'(sel)) +: 8];
    else
      hdr_byte = 8'h00;
  end
endmodule

// File: rtl/udp_hdr_streamer.sv
module udp_hdr_streamer
  import udp_hdr_pkg::*;
#(
  parameter int         PLEN_W = 11,
  parameter logic [7:0] TTL    = 8'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  input  logic [47:0]       cfg_dst_mac,
  input  logic [47:0]       cfg_src_mac,
  input  logic [31:0]       cfg_src_ip,
  input  logic [31:0]       cfg_dst_ip,
  input  logic [15:0]       cfg_src_port,
  input  logic [15:0]       cfg_dst_port,
  input  logic [PLEN_W-1:0] cfg_plen,
  input  logic [7:0]        pl_data,
  input  logic              pl_valid,
  output logic              pl_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last
);
  localparam int IDX_W = (PLEN_W + 1 > 7) ? PLEN_W + 1 : 7;

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [15:0]       csum_q;
  logic [PLEN_W-1:0] plen_q;
  logic              load_en;
  logic [15:0]       csum_new;
  logic [15:0]       tot_len_cfg, tot_len_q, udp_len_q;
  logic [IDX_W-1:0]  pay_end, frm_end;
  logic              in_hdr, in_pay, fire, is_last;
  logic [7:0]        hdr_byte;

  assign tot_len_cfg = 16'(cfg_plen) + 16'(IPH_BYTES + UDPH_BYTES);
  assign tot_len_q   = 16'(plen_q) + 16'(IPH_BYTES + UDPH_BYTES);
  assign udp_len_q   = 16'(plen_q) + 16'(UDPH_BYTES);

  udp_ipv4_csum #(.TTL(TTL)) u_csum (
    .tot_len (tot_len_cfg),
    .src_ip  (cfg_src_ip),
    .dst_ip  (cfg_dst_ip),
    .csum    (csum_new)
  );

  udp_hdr_bytes #(.TTL(TTL)) u_hdr (
    .sel      (idx_q[5:0]),
    .dst_mac  (cfg_dst_mac),
    .src_mac  (cfg_src_mac),
    .src_ip   (cfg_src_ip),
    .dst_ip   (cfg_dst_ip),
    .src_port (cfg_src_port),
    .dst_port (cfg_dst_port),
    .tot_len  (tot_len_q),
    .udp_len  (udp_len_q),
    .csum     (csum_q),
    .hdr_byte (hdr_byte)
  );

  always_comb begin
    pay_end  = IDX_W'(HDR_BYTES) + IDX_W'(plen_q);
    frm_end  = (pay_end < IDX_W'(MIN_FRAME)) ? IDX_W'(MIN_FRAME) : pay_end;
    in_hdr   = idx_q < IDX_W'(HDR_BYTES);
    in_pay   = !in_hdr && (idx_q < pay_end);
    tx_valid = busy_q && (in_pay ? pl_valid : 1'b1);
    pl_ready = busy_q && in_pay && tx_ready;
    tx_data  = in_hdr ? hdr_byte : (in_pay ? pl_data : 8'h00);
    is_last  = idx_q == (frm_end - IDX_W'(1));
    tx_last  = tx_valid && is_last;
    fire     = tx_valid && tx_ready;
    busy     = busy_q;
  end

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    load_en = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        idx_d   = '0;
        load_en = 1'b1;
      end
    end else if (fire) begin
      idx_d = idx_q + IDX_W'(1);
      if (is_last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csum_q <= '0;
      plen_q <= '0;
    end else if (load_en) begin
      csum_q <= csum_new;
      plen_q <= cfg_plen;
    end
  end
endmodule

// File: rtl/udp_hdr_streamer_chk.sv
module udp_hdr_streamer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       pl_ready,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_last
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_valid && !pl_ready && !tx_last)); // R1
  AST_PL_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> tx_ready); // R6
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && tx_ready) |=> !busy); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(tx_last && tx_ready)) |=> busy); // R9
  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R10
endmodule

bind udp_hdr_streamer udp_hdr_streamer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .pl_ready(pl_ready),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last)
);

// File: tb/tb_udp_hdr_streamer.sv
module tb_udp_hdr_streamer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy;
  logic [47:0] cfg_dst_mac, cfg_src_mac;
  logic [31:0] cfg_src_ip, cfg_dst_ip;
  logic [15:0] cfg_src_port, cfg_dst_port;
  logic [10:0] cfg_plen;
  logic [7:0]  pl_data = 8'h00;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        tx_last;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_b [0:127];
  logic [7:0] got_b [0:127];
  logic       got_l [0:127];
  logic [7:0] pay   [0:63];
  int nrx;

  always #2.5 clk = ~clk;

  udp_hdr_streamer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .cfg_dst_mac(cfg_dst_mac), .cfg_src_mac(cfg_src_mac),
    .cfg_src_ip(cfg_src_ip), .cfg_dst_ip(cfg_dst_ip),
    .cfg_src_port(cfg_src_port), .cfg_dst_port(cfg_dst_port),
    .cfg_plen(cfg_plen), .pl_data(pl_data), .pl_valid(pl_valid),
    .pl_ready(pl_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_csum(input int plen);
    int s;
    s = 32'h4500 + (28 + plen) + 32'h4011
      + cfg_src_ip[31:16] + cfg_src_ip[15:0] + cfg_dst_ip[31:16] + cfg_dst_ip[15:0];
    while (s > 16'hffff) s = (s & 16'hffff) + (s >>> 16);
    return ~s[15:0];
  endfunction

  function automatic int build_exp(input int plen);
    logic [335:0] h;
    logic [15:0] tl, ul, cs;
    int n;
    tl = 16'(28 + plen);
    ul = 16'(8 + plen);
    cs = ref_csum(plen);
    h = {cfg_dst_mac, cfg_src_mac, 16'h0800, 8'h45, 8'h00, tl, 16'h0, 16'h0,
         8'd64, 8'd17, cs, cfg_src_ip, cfg_dst_ip, cfg_src_port, cfg_dst_port, ul, 16'h0};
    for (int i = 0; i < 42; i++) exp_b[i] = h[8*(41-i) +: 8];
    for (int i = 0; i < plen; i++) exp_b[42+i] = pay[i];
    n = (42 + plen < 60) ? 60 : 42 + plen;
    for (int i = 42 + plen; i < n; i++) exp_b[i] = 8'h00;
    return n;
  endfunction

  // Runs one frame. gap: 0 steady, else tx_ready and pl_valid gapped.
  // extra_start: pulse start again mid-frame.
  task automatic run_frame(input int plen, input int gap, input bit extra_start);
    int n, pidx, cyc;
    bit pv;
    n = build_exp(plen);
    cfg_plen = 11'(plen);
    nrx = 0; pidx = 0; pv = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (nrx < n + 4 && cyc < 2000) begin
      @(negedge clk);
      start = extra_start && (cyc == 20 || cyc == 50);
      tx_ready = (gap == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (!pv) pv = (gap == 0) ? 1'b1 : ((cyc % 4) != 2);
      pl_valid = pv && (pidx < plen);
      pl_data = (pidx < plen) ? pay[pidx] : 8'hxx;
      #1;
      if (pl_valid && pl_ready) begin pidx++; pv = 1'b0; end
      if (tx_valid && tx_ready) begin
        if (nrx < 128) begin got_b[nrx] = tx_data; got_l[nrx] = tx_last; end
        nrx++;
      end
      if (!busy && nrx >= n) cyc = cyc + 500;
      cyc++;
    end
    start = 1'b0; tx_ready = 1'b0; pl_valid = 1'b0;
    chk(nrx == n, "R7/R9 frame length", nrx, n);
    for (int i = 0; i < n && i < nrx; i++) begin
      string r;
      if (i >= 16 && i <= 17 || i >= 38 && i <= 39) r = "R3";
      else if (i == 24 || i == 25) r = "R4";
      else if (i == 40 || i == 41) r = "R5";
      else if (i < 42) r = "R2";
      else if (i < 42 + plen) r = "R6";
      else r = "R7";
      chk(got_b[i] == exp_b[i], r, got_b[i], exp_b[i]);
      chk(got_l[i] == (i == n - 1), "R8 last marker", got_l[i], i == n - 1);
    end
    chk(pidx == plen, "R6 payload consumed", pidx, plen);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(!busy && !tx_valid, "R8/R9 idle after frame", busy, 0);
    end
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(tx_last == 1'b0, "R1 tx_last", tx_last, 0);
    chk(pl_ready == 1'b0, "R1 pl_ready", pl_ready, 0);
  endtask

  // R10: a stall must keep byte and valid
  task automatic t_stall;
    logic [7:0] d0;
    cfg_plen = 11'd4;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; tx_ready = 1'b0;
    #1 d0 = tx_data;
    chk(tx_valid, "R10 valid before stall", tx_valid, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(tx_valid && tx_data == d0, "R10 held byte", tx_data, d0);
    end
    tx_ready = 1'b1; pl_valid = 1'b1; pl_data = 8'h00;
    while (busy) @(negedge clk);
    tx_ready = 1'b0; pl_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfg_dst_mac = 48'h0011_2233_4455; cfg_src_mac = 48'h02AB_CDEF_0102;
    cfg_src_ip = 32'hA9FE_0102; cfg_dst_ip = 32'hA9FE_B15D;
    cfg_src_port = 16'd1024; cfg_dst_port = 16'd1024; cfg_plen = 11'd0;
    for (int i = 0; i < 64; i++) pay[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(4, 0, 1'b0);
    run_frame(18, 0, 1'b0);
    run_frame(30, 1, 1'b0);
    cfg_dst_mac = 48'hFFFF_FFFF_FFFF; cfg_src_mac = 48'h0A0B_0C0D_0E0F;
    cfg_src_ip = 32'hFFFF_FFFE; cfg_dst_ip = 32'hC0A8_0001;
    cfg_src_port = 16'hBEEF; cfg_dst_port = 16'h0035;
    run_frame(0, 1, 1'b0);
    run_frame(30, 1, 1'b1);
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule